// File: doc/BRIEF.md
# CRT Cut-off Measurement Sequencer

This block times the automatic black-level regulation of a three-gun colour picture tube. It watches a frame-retrace level and a line-start strobe. While retrace lasts it asks the analog side to sample the leakage current. When retrace ends it gives a single hold pulse, so the leakage value is kept for the rest of the frame. The next three line periods are then used as measurement lines, one colour gun per line. On each of those lines the block inserts a reference level, blanks the picture and selects the gun to be measured. After a settling delay it opens that gun's regulation loop.

After reset the tube is cold. The block forces a white level onto the luminance path and keeps every measurement strobe quiet. It leaves this warm-up state when the cathode-current-detected flag is seen for the first time. From then on it stays out of warm-up, even if the flag is lost, until the next reset. All analog quantities appear here only as digital flags and strobes.

Top module: `cutoff_seq_top`

## Requirements
- R1: While reset is asserted, and directly after it, white_force is 1 and leak_sample, leak_hold, meas_insert, blank_out, chan_sel and loop_en are all 0.
- R2: white_force falls one clock after cathode_seen is first sampled high. It stays 0 whatever cathode_seen does later, and only a reset sets it again.
- R3: While white_force is 1, leak_sample, leak_hold, meas_insert, blank_out, chan_sel and loop_en all stay 0, including across full retrace and line sequences.
- R4: Once warmed up, leak_sample is 1 from one clock after retrace rises until one clock after retrace falls.
- R5: Once warmed up, leak_hold is a pulse exactly one clock wide. It starts one clock after retrace falls.
- R6: The first three line_strobe pulses after retrace ends each start one measurement line, which lasts until the next strobe. chan_sel is one-hot: bit 0 (red) on the first line, bit 1 (green) on the second and bit 2 (blue) on the third. Each bit appears one clock after its strobe.
- R7: loop_en bit i is 1 only during measurement line i. It rises SETTLE_CYC clocks after chan_sel bit i rises and stays 1 until that line ends.
- R8: meas_insert is 1 for exactly the measurement lines. blank_out is 1 during the retrace interval (while leak_sample is 1) and during the measurement lines.
- R9: chan_sel, loop_en and meas_insert are 0 between the end of retrace and the first line strobe, from the fourth line strobe onwards, and on every later line until the next retrace.
- R10: A retrace rise during a measurement line ends that line at once: chan_sel and loop_en drop to 0 and leak_sample rises one clock later. After this retrace ends, the sequence starts again with red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retrace | input | 1 | High during the frame retrace interval |
| line_strobe | input | 1 | One-clock pulse at the start of each line |
| cathode_seen | input | 1 | Cathode current is detected |
| white_force | output | 1 | Forces a white level onto luminance (warm-up) |
| leak_sample | output | 1 | Leakage current sampling window |
| leak_hold | output | 1 | One-clock pulse that freezes the leakage value |
| meas_insert | output | 1 | Inserts the cut-off reference level |
| blank_out | output | 1 | Blanks the picture outputs |
| chan_sel | output | NUM_CH | One-hot gun select (bit 0 red, 1 green, 2 blue) |
| loop_en | output | NUM_CH | Per-gun regulation loop enable |

## Verification
The checker assumes that line_strobe is a single-clock pulse and that cathode_seen is already synchronous to clk. It also assumes that retrace stays in each level for at least two clocks, because the check on the hold pulse looks back two samples of retrace. The bench changes every input on the falling clock edge and keeps retrace high or low for several clocks at a time. Its line strobes are spaced many clocks apart and never fall on a retrace edge. A warm-up event is only given between frames, so no measurement line begins in mid-warm-up.

// File: rtl/cutoff_pkg.sv
package cutoff_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_RETRACE = 2'd1,
      ST_WAIT    = 2'd2,
      ST_MEAS    = 2'd3
   } seq_state_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cutoff_warmup.sv
module cutoff_warmup (
   input  logic clk,
   input  logic rst_n,
   input  logic cathode_seen,
   output logic warm_done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         warm_done <= 1'b0;
      else if (cathode_seen)
         warm_done <= 1'b1;
   end

endmodule

// File: rtl/cutoff_frame_fsm.sv
module cutoff_frame_fsm
   import cutoff_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   localparam int unsigned IDXW  = idx_width(NUM_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            retrace,
   input  logic            line_strobe,
   output seq_state_t      state,
   output logic [IDXW-1:0] idx,
   output logic            hold_pulse,
   output logic            advance
);

   localparam logic [IDXW-1:0] LAST = IDXW'(NUM_CH - 1);

   logic retrace_q;
   logic rise;
   logic fall;

   assign rise = retrace & ~retrace_q;
   assign fall = ~retrace & retrace_q;

   assign advance = line_strobe & ~rise &
                    ((state == ST_WAIT) || ((state == ST_MEAS) && (idx != LAST)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         retrace_q  <= 1'b0;
         state      <= ST_IDLE;
         idx        <= '0;
         hold_pulse <= 1'b0;
      end else begin
         retrace_q  <= retrace;
         hold_pulse <= 1'b0;
         if (rise) begin
            state <= ST_RETRACE;
            idx   <= '0;
         end else begin
            unique case (state)
               ST_RETRACE: if (fall) begin
                  state      <= ST_WAIT;
                  idx        <= '0;
                  hold_pulse <= 1'b1;
               end
               ST_WAIT: if (line_strobe) begin
                  state <= ST_MEAS;
                  idx   <= '0;
               end
               ST_MEAS: if (line_strobe) begin
                  if (idx == LAST) begin
                     state <= ST_IDLE;
                     idx   <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/cutoff_settle.sv
module cutoff_settle #(
   parameter int unsigned SETTLE_CYC = 4,
   localparam int unsigned CW        = $clog2(SETTLE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic settled
);

   localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= LIMIT;
      else if (restart)
         cnt <= '0;
      else if (cnt != LIMIT)
         cnt <= cnt + 1'b1;
   end

   assign settled = (cnt == LIMIT);

endmodule

// File: rtl/cutoff_seq_top.sv
module cutoff_seq_top
   import cutoff_pkg::*;
#(
   parameter int unsigned NUM_CH     = 3,
   parameter int unsigned SETTLE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retrace,
   input  logic              line_strobe,
   input  logic              cathode_seen,
   output logic              white_force,
   output logic              leak_sample,
   output logic              leak_hold,
   output logic              meas_insert,
   output logic              blank_out,
   output logic [NUM_CH-1:0] chan_sel,
   output logic [NUM_CH-1:0] loop_en
);

   localparam int unsigned IDXW = idx_width(NUM_CH);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("cutoff_seq_top: NUM_CH must be at least 1");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("cutoff_seq_top: SETTLE_CYC must be at least 1");
   end

   seq_state_t      state;
   logic [IDXW-1:0] idx;
   logic            hold_pulse;
   logic            advance;
   logic            warm_done;
   logic            settled;
   logic            in_meas;

   cutoff_warmup i_warm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cathode_seen (cathode_seen),
      .warm_done    (warm_done)
   );

   cutoff_frame_fsm #(.NUM_CH(NUM_CH)) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .retrace     (retrace),
      .line_strobe (line_strobe),
      .state       (state),
      .idx         (idx),
      .hold_pulse  (hold_pulse),
      .advance     (advance)
   );

   cutoff_settle #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (advance),
      .settled (settled)
   );

   assign white_force = ~warm_done;
   assign in_meas     = warm_done && (state == ST_MEAS);
   assign leak_sample = warm_done && (state == ST_RETRACE);
   assign leak_hold   = warm_done && hold_pulse;
   assign meas_insert = in_meas;
   assign blank_out   = in_meas || leak_sample;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign chan_sel[c] = in_meas && (idx == IDXW'(c));
      assign loop_en[c]  = chan_sel[c] && settled;
   end

endmodule

// File: rtl/cutoff_seq_chk.sv
module cutoff_seq_chk #(
   parameter int unsigned NUM_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              retrace,
   input logic              cathode_seen,
   input logic              white_force,
   input logic              leak_sample,
   input logic              leak_hold,
   input logic              meas_insert,
   input logic [NUM_CH-1:0] chan_sel,
   input logic [NUM_CH-1:0] loop_en
);

   assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_sel));

   assert_loop_in_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en & ~chan_sel) == '0);

   assert_warm_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      white_force |-> (chan_sel == '0 && loop_en == '0 && !leak_hold && !leak_sample));

   assert_warm_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(white_force));

   assert_warm_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cathode_seen |=> !white_force);

   assert_hold_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      leak_hold |=> !leak_hold);

   assert_hold_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      leak_hold |-> ($past(retrace, 2) && !$past(retrace)));

   assert_no_meas_in_retrace_R8: assert property (@(posedge clk) disable iff (!rst_n)
      leak_sample |-> !meas_insert);

endmodule

bind cutoff_seq_top cutoff_seq_chk #(.NUM_CH(NUM_CH)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .retrace      (retrace),
   .cathode_seen (cathode_seen),
   .white_force  (white_force),
   .leak_sample  (leak_sample),
   .leak_hold    (leak_hold),
   .meas_insert  (meas_insert),
   .chan_sel     (chan_sel),
   .loop_en      (loop_en)
);

// File: tb/test_cutoff_seq_top.sv
`timescale 1ns/1ps
module test_cutoff_seq_top;

   localparam int S = 4;
   localparam int L = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       retrace = 1'b0;
   logic       line_strobe = 1'b0;
   logic       cathode_seen = 1'b0;
   logic       white_force;
   logic       leak_sample;
   logic       leak_hold;
   logic       meas_insert;
   logic       blank_out;
   logic [2:0] chan_sel;
   logic [2:0] loop_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   cutoff_seq_top #(.NUM_CH(3), .SETTLE_CYC(S)) i_cutoff_seq_top (
      .clk          (clk),
      .rst_n        (rst_n),
      .retrace      (retrace),
      .line_strobe  (line_strobe),
      .cathode_seen (cathode_seen),
      .white_force  (white_force),
      .leak_sample  (leak_sample),
      .leak_hold    (leak_hold),
      .meas_insert  (meas_insert),
      .blank_out    (blank_out),
      .chan_sel     (chan_sel),
      .loop_en      (loop_en)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk_quiet(input string tag);
      chk({5'b0, chan_sel}, 8'h0, {tag, " chan_sel"});
      chk({5'b0, loop_en}, 8'h0, {tag, " loop_en"});
      chk({7'b0, meas_insert}, 8'h0, {tag, " meas_insert"});
   endtask

   // one retrace interval of len clocks, then the hold pulse
   task automatic do_retrace(input int len, input bit warm);
      retrace = 1'b1;
      for (int j = 1; j <= len; j++) begin
         tick();
         chk({7'b0, leak_sample}, {7'b0, warm}, "R4 leak_sample in retrace");
         chk({7'b0, blank_out}, {7'b0, warm}, "R8 blank in retrace");
         chk_quiet("R3/R9 retrace");
      end
      retrace = 1'b0;
      tick();
      chk({7'b0, leak_sample}, 8'h0, "R4 leak_sample after retrace");
      chk({7'b0, leak_hold}, {7'b0, warm}, "R5 hold pulse");
      tick();
      chk({7'b0, leak_hold}, 8'h0, "R5 hold single");
      chk_quiet("R9 gap before first line");
   endtask

   // one line of len clocks; ch = -1 means no measurement expected
   task automatic do_line(input int ch, input int len);
      logic [2:0] e;
      e = (ch >= 0) ? 3'(1 << ch) : 3'b000;
      line_strobe = 1'b1;
      for (int j = 1; j <= len; j++) begin
         tick();
         line_strobe = 1'b0;
         chk({5'b0, chan_sel}, {5'b0, e}, "R6 chan_sel");
         chk({5'b0, loop_en}, {5'b0, (j > S) ? e : 3'b000}, "R7 loop_en");
         chk({7'b0, meas_insert}, {7'b0, (ch >= 0)}, "R8 meas_insert");
         chk({7'b0, blank_out}, {7'b0, (ch >= 0)}, "R8 blank in line");
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick();
      chk({7'b0, white_force}, 8'h1, "R1 white_force in reset");
      chk_quiet("R1 reset");
      chk({6'b0, leak_sample, leak_hold}, 8'h0, "R1 leak outputs");
      rst_n = 1'b1;
      tick();
      chk({7'b0, white_force}, 8'h1, "R1 white_force after reset");
      chk({7'b0, blank_out}, 8'h0, "R1 blank_out");
   endtask

   task automatic t_warmup_frame();
      do_retrace(4, 1'b0);
      for (int k = 0; k < 4; k++) do_line(-1, L);
      chk({7'b0, white_force}, 8'h1, "R3 still warming");
   endtask

   task automatic t_detect();
      cathode_seen = 1'b1;
      tick();
      cathode_seen = 1'b0;
      chk({7'b0, white_force}, 8'h0, "R2 release on detect");
      for (int k = 0; k < 5; k++) tick();
      chk({7'b0, white_force}, 8'h0, "R2 stays released");
   endtask

   task automatic t_full_frame();
      do_retrace(6, 1'b1);
      tick();
      chk_quiet("R9 extra gap");
      do_line(0, L);
      do_line(1, L);
      do_line(2, L);
      do_line(-1, L);
      do_line(-1, L);
   endtask

   task automatic t_abort();
      do_retrace(4, 1'b1);
      do_line(0, 6);
      retrace = 1'b1;
      tick();
      chk({5'b0, chan_sel}, 8'h0, "R10 abort chan_sel");
      chk({5'b0, loop_en}, 8'h0, "R10 abort loop_en");
      chk({7'b0, leak_sample}, 8'h1, "R10 abort leak_sample");
      do_retrace(3, 1'b1);
      do_line(0, L);
      do_line(1, L);
   endtask

   task automatic t_rereset();
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      chk({7'b0, white_force}, 8'h1, "R2 reset re-enters warm-up");
      do_retrace(3, 1'b0);
      do_line(-1, L);
   endtask

   initial begin
      tick();
      t_reset();
      t_warmup_frame();
      t_detect();
      t_full_frame();
      t_abort();
      t_rereset();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule